// File: doc/BRIEF.md
# SDRAM Command Decoder with Burst Termination

This block is the command front end of a single-data-rate synchronous DRAM device model. On every rising clock edge it samples chip select, the three strobes and the clock enable, classifies the command, and acts on the ones that steer data: mode register programming, read, write and burst stop. It keeps the programmed mode register (CAS latency, burst ordering, burst length) together with a flag that says whether that value can be trusted. It steps a column counter through each burst and drives the read side of the data bus through a latency pipeline. The memory array, refresh and row timing sit outside. The array answers the read column on `rd_col` with `rd_word` in the same cycle, and it takes accepted write beats from `wr_valid`, `wr_col` and `wr_word`.

The burst engine is a three-state machine. `BS_IDLE` moves to `BS_READ` or `BS_WRITE` when a read or write is accepted with a burst length above one. Either busy state returns to `BS_IDLE` after its last beat (the burst-done transition) or on a burst stop (the stop transition). A busy state jumps straight to the other busy state, or restarts itself, when a new read or write is accepted (the interrupt transition). Every state holds while the clock enable is low (the suspend transition). Read beats enter a shift pipeline whose tap is picked by the programmed CAS latency. A burst stop therefore cuts reads off only after the beats already issued have drained, while a write is cut off in the stop cycle itself.

Top module: `sdcmd_decoder`

## Requirements
- R1: After reset `dq_oe`, `wr_valid`, `cmd_err` and `mode_valid` are all low.
- R2: Commands are coded as {cs_n,ras_n,cas_n,we_n}: 0000 mode set, 0101 read, 0100 write, 0110 burst stop, 0111 no-op. With cs_n high the other strobes and the address are ignored, so a deselect with ras_n, cas_n and we_n low changes neither `mode_valid` nor `cmd_err`.
- R3: A mode set sampled while `banks_idle` is high and its fields are legal sets `mode_valid` and loads {ba,addr} into `mode_reg`, visible one cycle later. The fields are: burst length code in value bits 2:0 (0,1,2,3 give 1,2,4,8 beats, 7 gives the full page), ordering in bit 3 (0 sequential, 1 interleaved) and CAS latency in bits 6:4.
- R4: A mode set sampled while `banks_idle` is low, or one carrying a burst length code of 4, 5 or 6 or a CAS latency outside CL_MIN..CL_MAX, leaves `mode_reg` and `mode_valid` unchanged and raises `cmd_err` for one cycle.
- R5: A read or write sampled while `mode_valid` is low raises `cmd_err` for one cycle and produces no read or write beat.
- R6: For a read sampled at edge E, beat k is driven with `dq_oe` high and `dq_out` equal to `rd_word` in the cycle after edge E+CL-1+k. For a write sampled at edge E, the `dq_in` word sampled at edge E+k appears on `wr_word` with `wr_valid` high in the following cycle.
- R7: Beat k of a burst of length BL starting at column C addresses the column whose bits above log2(BL) equal those of C and whose low bits are (C+k) mod BL for sequential ordering or C XOR k for interleaved ordering.
- R8: A full-page burst always runs sequentially, wraps at the end of the page and continues until it is stopped or replaced.
- R9: A burst stop sampled at edge S during a read issues no further beats: the read returns exactly S-E beats, and `dq_oe` is low from edge S+CL-1 on.
- R10: A burst stop sampled at edge S during a write discards the `dq_in` word sampled at S, so `wr_valid` is low in the cycle after S and stays low.
- R11: A read or write accepted during a burst ends that burst and starts the new one at beat 0 in the same cycle. An accepted write also drops every read beat still pending, so `dq_oe` is low from that edge on.
- R12: An edge that samples `cke` low is a suspended cycle. No command is decoded, no beat is accepted (`wr_valid` is low afterwards), and the burst position and the read pipeline hold, so `dq_oe` keeps its value.
- R13: `dpd_exit` high at an edge clears `mode_valid` and takes priority over a mode set sampled at the same edge. Reads and writes are then rejected until a new mode set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low suspends the cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank address; upper part of the mode value |
| addr | input | A_W | Address; column for read and write, lower part of the mode value |
| banks_idle | input | 1 | High when every bank is precharged |
| dpd_exit | input | 1 | One-cycle pulse marking exit from deep power down |
| dq_in | input | DQ_W | Write data from the bus |
| rd_word | input | DQ_W | Array word at column `rd_col` |
| dq_out | output | DQ_W | Read data driven onto the bus, zero when not driving |
| dq_oe | output | 1 | Bus output enable |
| rd_col | output | COL_W | Column of the read beat now on the bus |
| wr_valid | output | 1 | A write beat was accepted on the previous edge |
| wr_col | output | COL_W | Column of the accepted write beat |
| wr_word | output | DQ_W | Data of the accepted write beat |
| mode_valid | output | 1 | Mode register holds a programmed value |
| mode_reg | output | BA_W+A_W | Stored mode value {ba,addr} |
| cmd_err | output | 1 | One-cycle flag for a rejected command |

## Verification
The bench builds the decoder with a 4-bit column (16-word page), a 10-bit address and a 16-bit data path. The short page lets a full-page write wrap past its last column within twenty beats. The default latency bounds are kept, and the bench reprograms the mode register between latency 2 and latency 3 and between both orderings. That exercises both taps of the read pipeline and shows how the burst stop and the write flush line up against each latency.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_BST,
        CMD_READ,
        CMD_WRITE,
        CMD_ACT,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } cmd_e;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_READ,
        BS_WRITE
    } burst_e;

    // Field positions inside the programmed mode value
    localparam int MR_BL_LSB = 0;
    localparam int MR_IL_BIT = 3;
    localparam int MR_CL_LSB = 4;
    localparam int MR_MIN_W  = 7;

    localparam logic [2:0] BL_FULL_PAGE = 3'd7;

    function automatic logic bl_code_legal(input logic [2:0] code);
        return (code <= 3'd3) || (code == BL_FULL_PAGE);
    endfunction

endpackage

// File: rtl/sdcmd_classify.sv
module sdcmd_classify
    import sdcmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_REF;
                3'b010:  cmd = CMD_PRE;
                3'b011:  cmd = CMD_ACT;
                3'b100:  cmd = CMD_WRITE;
                3'b101:  cmd = CMD_READ;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_modereg.sv
module sdcmd_modereg
    import sdcmd_pkg::*;
#(
    parameter int MR_W   = 15,
    parameter int CL_MIN = 2,
    parameter int CL_MAX = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  cmd_e            cmd,
    input  logic            banks_idle,
    input  logic            dpd_exit,
    input  logic [MR_W-1:0] value,
    output logic            mode_valid,
    output logic [MR_W-1:0] mode_reg,
    output logic            mrs_reject
);

    logic       mrs_seen;
    logic       fields_ok;
    logic       accept;
    logic [2:0] cl_field;

    assign cl_field  = value[MR_CL_LSB +: 3];
    assign mrs_seen  = en && (cmd == CMD_MRS);
    assign fields_ok = bl_code_legal(value[MR_BL_LSB +: 3])
                       && (cl_field >= 3'(CL_MIN)) && (cl_field <= 3'(CL_MAX));
    assign accept     = mrs_seen && banks_idle && fields_ok;
    assign mrs_reject = mrs_seen && !(banks_idle && fields_ok);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_valid <= 1'b0;
            mode_reg   <= '0;
        end else if (dpd_exit) begin
            mode_valid <= 1'b0;
        end else if (accept) begin
            mode_valid <= 1'b1;
            mode_reg   <= value;
        end
    end

    // R3: the valid flag only rises after an idle-bank mode set
    assert_valid_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_valid) |-> $past(en && cmd == CMD_MRS && banks_idle && !dpd_exit));

    // R13: deep power down exit always leaves the value untrusted
    assert_dpd_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
        dpd_exit |=> !mode_valid);

    // R4: busy banks never let the stored value change
    assert_busy_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cmd == CMD_MRS && !banks_idle) |=> $stable(mode_reg));

endmodule

// File: rtl/sdcmd_burst.sv
module sdcmd_burst
    import sdcmd_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  cmd_e             cmd,
    input  logic             mode_valid,
    input  logic [2:0]       bl_code,
    input  logic             il_mode,
    input  logic [COL_W-1:0] col_in,
    output logic             beat,
    output logic             beat_wr,
    output logic [COL_W-1:0] beat_col,
    output logic             start_wr,
    output logic             rw_err
);

    burst_e           state_q, state_d;
    logic [COL_W-1:0] k_q, k_d;
    logic [COL_W-1:0] base_q, base_d;
    logic [COL_W-1:0] mask_q, mask_d;
    logic             il_q, il_d;
    logic             full_q, full_d;

    logic             rd_cmd, wr_cmd, start, stop;
    logic [COL_W-1:0] new_mask;
    logic             new_full;

    function automatic logic [COL_W-1:0] col_at(
        input logic [COL_W-1:0] base,
        input logic [COL_W-1:0] k,
        input logic [COL_W-1:0] mask,
        input logic             il
    );
        logic [COL_W-1:0] low;
        low = il ? (base ^ k) : (base + k);
        return (base & ~mask) | (low & mask);
    endfunction

    assign rd_cmd   = en && (cmd == CMD_READ);
    assign wr_cmd   = en && (cmd == CMD_WRITE);
    assign start    = (rd_cmd || wr_cmd) && mode_valid;
    assign rw_err   = (rd_cmd || wr_cmd) && !mode_valid;
    assign stop     = en && (cmd == CMD_BST);
    assign new_full = (bl_code == BL_FULL_PAGE);

    always_comb begin
        unique case (bl_code)
            3'd0:    new_mask = '0;
            3'd1:    new_mask = COL_W'(1);
            3'd2:    new_mask = COL_W'(3);
            3'd3:    new_mask = COL_W'(7);
            default: new_mask = '1;
        endcase
    end

    // Next state and beat outputs
    always_comb begin
        state_d  = state_q;
        k_d      = k_q;
        base_d   = base_q;
        mask_d   = mask_q;
        il_d     = il_q;
        full_d   = full_q;
        beat     = 1'b0;
        beat_wr  = 1'b0;
        beat_col = '0;
        start_wr = 1'b0;
        if (start) begin
            base_d   = col_in;
            mask_d   = new_mask;
            il_d     = il_mode && !new_full;
            full_d   = new_full;
            k_d      = COL_W'(1);
            beat     = 1'b1;
            beat_wr  = wr_cmd;
            beat_col = col_in;
            start_wr = wr_cmd;
            if (new_mask == '0) begin
                state_d = BS_IDLE;
            end else begin
                state_d = wr_cmd ? BS_WRITE : BS_READ;
            end
        end else if (stop) begin
            state_d = BS_IDLE;
        end else if (en) begin
            unique case (state_q)
                BS_IDLE: begin
                end
                BS_READ, BS_WRITE: begin
                    beat     = 1'b1;
                    beat_wr  = (state_q == BS_WRITE);
                    beat_col = col_at(base_q, k_q, mask_q, il_q);
                    k_d      = k_q + COL_W'(1);
                    if (!full_q && (k_q == mask_q)) begin
                        state_d = BS_IDLE;
                    end
                end
                default: state_d = BS_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BS_IDLE;
            k_q     <= '0;
            base_q  <= '0;
            mask_q  <= '0;
            il_q    <= 1'b0;
            full_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            k_q     <= k_d;
            base_q  <= base_d;
            mask_q  <= mask_d;
            il_q    <= il_d;
            full_q  <= full_d;
        end
    end

    // R9: a stop with no competing read or write leaves the engine idle
    assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> (state_q == BS_IDLE));

    // R7: a bounded burst never counts past its length
    assert_beat_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != BS_IDLE && !full_q) |-> (k_q <= mask_q && k_q != '0));

    // R5: a rejected read or write never starts a burst
    assert_reject_no_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_err && state_q == BS_IDLE) |=> (state_q == BS_IDLE));

endmodule

// File: rtl/sdcmd_rdpipe.sv
module sdcmd_rdpipe #(
    parameter int COL_W  = 9,
    parameter int CL_MAX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             flush,
    input  logic             in_valid,
    input  logic [COL_W-1:0] in_col,
    input  logic [2:0]       cl,
    output logic             out_valid,
    output logic [COL_W-1:0] out_col
);

    localparam int IDX_W = (CL_MAX > 1) ? $clog2(CL_MAX) : 1;

    logic             stg_v [CL_MAX];
    logic [COL_W-1:0] stg_c [CL_MAX];
    logic [IDX_W-1:0] tap;

    assign tap = IDX_W'(cl - 3'd1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CL_MAX; i++) begin
                stg_v[i] <= 1'b0;
                stg_c[i] <= '0;
            end
        end else if (en) begin
            stg_v[0] <= in_valid && !flush;
            stg_c[0] <= in_col;
            for (int i = 1; i < CL_MAX; i++) begin
                stg_v[i] <= stg_v[i-1] && !flush;
                stg_c[i] <= stg_c[i-1];
            end
        end
    end

    always_comb begin
        if (int'(tap) < CL_MAX) begin
            out_valid = stg_v[tap];
            out_col   = stg_c[tap];
        end else begin
            out_valid = 1'b0;
            out_col   = '0;
        end
    end

    // R11: a flush leaves nothing to drive in the next cycle
    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && flush) |=> !out_valid);

endmodule

// File: rtl/sdcmd_decoder.sv
module sdcmd_decoder
    import sdcmd_pkg::*;
#(
    parameter int A_W    = 13,
    parameter int BA_W   = 2,
    parameter int COL_W  = 9,
    parameter int DQ_W   = 16,
    parameter int CL_MIN = 2,
    parameter int CL_MAX = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [A_W-1:0]       addr,
    input  logic                 banks_idle,
    input  logic                 dpd_exit,
    input  logic [DQ_W-1:0]      dq_in,
    input  logic [DQ_W-1:0]      rd_word,
    output logic [DQ_W-1:0]      dq_out,
    output logic                 dq_oe,
    output logic [COL_W-1:0]     rd_col,
    output logic                 wr_valid,
    output logic [COL_W-1:0]     wr_col,
    output logic [DQ_W-1:0]      wr_word,
    output logic                 mode_valid,
    output logic [BA_W+A_W-1:0]  mode_reg,
    output logic                 cmd_err
);

    localparam int MR_W = BA_W + A_W;

    cmd_e             cmd;
    logic             mrs_reject;
    logic             beat, beat_wr, start_wr, rw_err;
    logic [COL_W-1:0] beat_col;

    sdcmd_classify u_classify (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdcmd_modereg #(
        .MR_W   (MR_W),
        .CL_MIN (CL_MIN),
        .CL_MAX (CL_MAX)
    ) u_modereg (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cke),
        .cmd        (cmd),
        .banks_idle (banks_idle),
        .dpd_exit   (dpd_exit),
        .value      ({ba, addr}),
        .mode_valid (mode_valid),
        .mode_reg   (mode_reg),
        .mrs_reject (mrs_reject)
    );

    sdcmd_burst #(
        .COL_W (COL_W)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cke),
        .cmd        (cmd),
        .mode_valid (mode_valid),
        .bl_code    (mode_reg[MR_BL_LSB +: 3]),
        .il_mode    (mode_reg[MR_IL_BIT]),
        .col_in     (addr[COL_W-1:0]),
        .beat       (beat),
        .beat_wr    (beat_wr),
        .beat_col   (beat_col),
        .start_wr   (start_wr),
        .rw_err     (rw_err)
    );

    sdcmd_rdpipe #(
        .COL_W  (COL_W),
        .CL_MAX (CL_MAX)
    ) u_rdpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cke),
        .flush     (start_wr),
        .in_valid  (beat && !beat_wr),
        .in_col    (beat_col),
        .cl        (mode_reg[MR_CL_LSB +: 3]),
        .out_valid (dq_oe),
        .out_col   (rd_col)
    );

    assign dq_out = dq_oe ? rd_word : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_err  <= 1'b0;
            wr_valid <= 1'b0;
            wr_col   <= '0;
            wr_word  <= '0;
        end else begin
            cmd_err  <= rw_err || mrs_reject;
            wr_valid <= beat && beat_wr;
            if (beat && beat_wr) begin
                wr_col  <= beat_col;
                wr_word <= dq_in;
            end
        end
    end

    // R11: write beats and driven read data never overlap
    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !dq_oe);

    // R12: a suspended cycle holds the bus and accepts no write data
    assert_suspend_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(dq_oe) && !wr_valid));

    // R10: a stop sampled in a running cycle accepts no write data
    assert_stop_drops_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && ras_n && cas_n && !we_n) |=> !wr_valid);

endmodule

// File: tb/tb_sdcmd_decoder.sv
module tb_sdcmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int A_W   = 10;
    localparam int BA_W  = 2;
    localparam int COL_W = 4;
    localparam int DQ_W  = 16;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_MRS = 4'b0000;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_BST = 4'b0110;

    typedef struct {
        int cyc;
        int col;
        int data;
    } beat_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cke = 1'b1;
    logic                cs_n, ras_n, cas_n, we_n;
    logic [BA_W-1:0]     ba = '0;
    logic [A_W-1:0]      addr = '0;
    logic                banks_idle = 1'b1;
    logic                dpd_exit = 1'b0;
    logic [DQ_W-1:0]     dq_in, rd_word, dq_out, wr_word;
    logic                dq_oe, wr_valid, mode_valid, cmd_err;
    logic [COL_W-1:0]    rd_col, wr_col;
    logic [BA_W+A_W-1:0] mode_reg;

    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    e0;
    beat_t rq[$];
    beat_t wq[$];

    initial {cs_n, ras_n, cas_n, we_n} = C_NOP;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign dq_in   = {8'h5A, 8'(cyc)};
    assign rd_word = 16'hA500 | 16'(rd_col);

    sdcmd_decoder #(
        .A_W (A_W), .BA_W (BA_W), .COL_W (COL_W), .DQ_W (DQ_W)
    ) dut (
        .clk (clk), .rst_n (rst_n), .cke (cke),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr), .banks_idle (banks_idle), .dpd_exit (dpd_exit),
        .dq_in (dq_in), .rd_word (rd_word), .dq_out (dq_out), .dq_oe (dq_oe),
        .rd_col (rd_col), .wr_valid (wr_valid), .wr_col (wr_col), .wr_word (wr_word),
        .mode_valid (mode_valid), .mode_reg (mode_reg), .cmd_err (cmd_err)
    );

    function automatic int col_of(int base, int k, int bl, bit il);
        int m = bl - 1;
        int low = il ? (base ^ k) : (base + k);
        return ((base & ~m) | (low & m)) & ((1 << COL_W) - 1);
    endfunction

    // Expected read beats for a read sampled at edge e (R6, R7)
    task automatic push_rd(int e, int base, int n, int bl, bit il, int cl);
        for (int k = 0; k < n; k++) begin
            beat_t b;
            b.cyc  = e + k + cl - 1;
            b.col  = col_of(base, k, bl, il);
            b.data = 'hA500 | b.col;
            rq.push_back(b);
        end
    endtask

    // Expected write beat k accepted at edge e
    task automatic push_wr(int e, int base, int k, int bl, bit il);
        beat_t b;
        b.cyc  = e;
        b.col  = col_of(base, k, bl, il);
        b.data = 'h5A00 | ((e - 1) & 255);
        wq.push_back(b);
    endtask

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(logic [3:0] c, int a);
        {cs_n, ras_n, cas_n, we_n} = c;
        addr = a[A_W-1:0];
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        addr = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: pops expected beats and compares them as they appear
    always @(negedge clk) begin
        if (rst_n) begin
            beat_t b;
            while (rq.size() > 0 && rq[0].cyc < cyc) begin
                n_cmp++; n_bad++;
                $display("FAIL R6 read beat missing: actual none expected col %0h at %0d", rq[0].col, rq[0].cyc);
                void'(rq.pop_front());
            end
            if (dq_oe) begin
                n_cmp++;
                if (rq.size() > 0 && rq[0].cyc == cyc) begin
                    b = rq.pop_front();
                    if (int'(rd_col) != b.col || int'(dq_out) != b.data) begin
                        n_bad++;
                        $display("FAIL R7 read beat: actual col %0h data %0h expected col %0h data %0h",
                                 rd_col, dq_out, b.col, b.data);
                    end
                end else begin
                    n_bad++;
                    $display("FAIL R9 unexpected read beat: actual col %0h expected none at %0d", rd_col, cyc);
                end
            end
            while (wq.size() > 0 && wq[0].cyc < cyc) begin
                n_cmp++; n_bad++;
                $display("FAIL R6 write beat missing: actual none expected col %0h at %0d", wq[0].col, wq[0].cyc);
                void'(wq.pop_front());
            end
            if (wr_valid) begin
                n_cmp++;
                if (wq.size() > 0 && wq[0].cyc == cyc) begin
                    b = wq.pop_front();
                    if (int'(wr_col) != b.col || int'(wr_word) != b.data) begin
                        n_bad++;
                        $display("FAIL R7 write beat: actual col %0h data %0h expected col %0h data %0h",
                                 wr_col, wr_word, b.col, b.data);
                    end
                end else begin
                    n_bad++;
                    $display("FAIL R10 unexpected write beat: actual col %0h expected none at %0d", wr_col, cyc);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check("R1 dq_oe", dq_oe, 0);
        check("R1 wr_valid", wr_valid, 0);
        check("R1 mode_valid", mode_valid, 0);
        check("R1 cmd_err", cmd_err, 0);

        // R5: read and write rejected before programming
        issue(C_RD, 3);
        check("R5 read rejected", cmd_err, 1);
        idle(4);
        issue(C_WR, 3);
        check("R5 write rejected", cmd_err, 1);
        idle(3);

        // R2: deselect ignores the strobes
        issue(4'b1000, 'h22);
        check("R2 deselect mode_valid", mode_valid, 0);
        check("R2 deselect cmd_err", cmd_err, 0);

        // R4: busy banks and reserved fields are refused
        banks_idle = 1'b0;
        issue(C_MRS, 'h22);
        check("R4 busy err", cmd_err, 1);
        check("R4 busy valid", mode_valid, 0);
        banks_idle = 1'b1;
        issue(C_MRS, 'h25);
        check("R4 bl code 5 err", cmd_err, 1);
        issue(C_MRS, 'h42);
        check("R4 latency 4 err", cmd_err, 1);
        check("R4 still invalid", mode_valid, 0);

        // R3: legal mode set, latency 2, sequential, 4 beats
        issue(C_MRS, 'h22);
        check("R3 valid", mode_valid, 1);
        check("R3 value", mode_reg, 'h22);
        check("R3 no err", cmd_err, 0);

        // R6 R7: sequential read wraps inside its 4-beat block
        e0 = cyc + 1;
        push_rd(e0, 5, 4, 4, 0, 2);
        issue(C_RD, 5);
        idle(8);

        // R4: busy banks keep the stored value
        banks_idle = 1'b0;
        issue(C_MRS, 'h3B);
        check("R4 busy keeps value", mode_reg, 'h22);
        banks_idle = 1'b1;

        // R7: interleaved 8-beat read at latency 3
        issue(C_MRS, 'h3B);
        check("R3 reprogram", mode_reg, 'h3B);
        e0 = cyc + 1;
        push_rd(e0, 11, 8, 8, 1, 3);
        issue(C_RD, 11);
        idle(12);

        // R9: stop three cycles into a latency-3 read
        e0 = cyc + 1;
        push_rd(e0, 0, 3, 8, 1, 3);
        issue(C_RD, 0);
        idle(2);
        issue(C_BST, 0);
        idle(1);
        check("R9 last beat still driven", dq_oe, 1);
        idle(1);
        check("R9 bus released", dq_oe, 0);
        idle(6);

        // R10: stop two beats into a write
        issue(C_MRS, 'h22);
        e0 = cyc + 1;
        push_wr(e0, 4, 0, 4, 0);
        push_wr(e0 + 1, 4, 1, 4, 0);
        issue(C_WR, 4);
        idle(1);
        issue(C_BST, 0);
        check("R10 stop word discarded", wr_valid, 0);
        idle(4);

        // R6: complete sequential write
        e0 = cyc + 1;
        for (int k = 0; k < 4; k++) push_wr(e0 + k, 6, k, 4, 0);
        issue(C_WR, 6);
        idle(6);

        // R11: read interrupted by read
        e0 = cyc + 1;
        push_rd(e0, 0, 2, 4, 0, 2);
        push_rd(e0 + 2, 8, 4, 4, 0, 2);
        issue(C_RD, 0);
        idle(1);
        issue(C_RD, 8);
        idle(8);

        // R11: write drops pending read data
        e0 = cyc + 1;
        push_rd(e0, 0, 1, 4, 0, 2);
        for (int k = 0; k < 4; k++) push_wr(e0 + 2 + k, 12, k, 4, 0);
        issue(C_RD, 0);
        idle(1);
        issue(C_WR, 12);
        check("R11 read flushed by write", dq_oe, 0);
        idle(6);

        // R8: full-page write wraps the 16-column page
        issue(C_MRS, 'h27);
        e0 = cyc + 1;
        for (int k = 0; k < 20; k++) push_wr(e0 + k, 14, k, 16, 0);
        issue(C_WR, 14);
        idle(19);
        issue(C_BST, 0);
        idle(3);

        // R12: one suspended cycle inside a write burst
        issue(C_MRS, 'h22);
        e0 = cyc + 1;
        push_wr(e0, 8, 0, 4, 0);
        push_wr(e0 + 1, 8, 1, 4, 0);
        push_wr(e0 + 3, 8, 2, 4, 0);
        push_wr(e0 + 4, 8, 3, 4, 0);
        issue(C_WR, 8);
        idle(1);
        cke = 1'b0;
        @(negedge clk);
        check("R12 suspended cycle takes no beat", wr_valid, 0);
        cke = 1'b1;
        idle(4);

        // R13: power-down exit beats a simultaneous mode set
        dpd_exit = 1'b1;
        issue(C_MRS, 'h22);
        dpd_exit = 1'b0;
        check("R13 valid cleared", mode_valid, 0);
        issue(C_RD, 0);
        check("R13 read rejected", cmd_err, 1);
        idle(4);
        issue(C_MRS, 'h22);
        check("R13 reprogrammed", mode_valid, 1);

        idle(8);
        check("R6 read queue drained", rq.size(), 0);
        check("R6 write queue drained", wq.size(), 0);
        summary();
        $finish;
    end

endmodule